// File: doc/BRIEF.md
# DMA Logical-to-Physical Page Translator

This block sits between DMA channels and the memory system. A channel presents a 24-bit logical address. The block answers with a 29-bit physical address. The logical space is cut into 4096-byte pages, so 12 address bits select a page and the low 12 bits are kept as the byte offset. Each page's physical frame is stored in a table in system memory. Software owns that table and points the block at it with a base register. A limit register gives the table's size in bytes.

Each table entry takes 8 bytes. The low 32-bit word holds the frame; the upper word is left for software. A small fully associative cache keeps recent translations, so a repeated page does not cost a memory read. Software drops every cached translation by writing the invalidate register. When a lookup falls outside the table, the block keeps that logical address in one capture register. When the table read itself fails, the logical address goes into a second capture register.

Top module: `dma_page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_req` and both capture registers are 0. The base and limit registers are also 0, so every lookup returns the range-fault status until software programs the limit.
- R2: On a cache miss, `mem_req` pulses for exactly one cycle, in the cycle after the request is accepted. `mem_addr` is (base + page·8) truncated to 29 bits, where page = laddr[23:12].
- R3: A fetched entry gives the physical address frame + laddr[11:0], truncated to 29 bits. The frame is the read data's bits [28:0], and bits [31:29] are ignored. The response has status 0 and comes in the cycle after `mem_rsp_valid`.
- R4: A lookup with page·8 ≥ limit returns status 1 and a zero address in the cycle after acceptance. It issues no memory read, and `bad_xlate_addr` takes the logical address.
- R5: A table read that returns `mem_rsp_err` gives status 2 and loads `fetch_fail_addr` with the logical address. The entry is not cached, so the next lookup of that page reads memory again.
- R6: A lookup that hits the cache answers with status 0 in the cycle after acceptance and issues no memory read.
- R7: The cache holds 4 pages. Fills go round-robin into the slots, and the slot pointer moves only on a fill. Cycling through 5 distinct pages therefore misses every time, and cycling through 4 pages hits once they are loaded.
- R8: Register select codes are 0 for base, 1 for limit and 2 for invalidate; code 3 does nothing. Any write with select 2, whatever its data (zero included), drops every cached page, so the next lookup reads memory.
- R9: If an invalidate write comes in the same cycle a lookup is accepted, the lookup is treated as a miss. If it comes while a fetch is outstanding, or in the same cycle as the fetch response, the response is still delivered but is not cached.
- R10: While a fetch is outstanding, `req_ready` is 0 and any request presented is ignored: it causes no read and gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 limit, 2 invalidate |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_laddr | input | 24 | Logical address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 range fault, 2 table read fault |
| rsp_paddr | output | 29 | Translated physical address |
| mem_req | output | 1 | Table read request pulse |
| mem_addr | output | 29 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table read data (frame word) |
| mem_rsp_err | input | 1 | Table read failed |
| bad_xlate_addr | output | 24 | Last logical address that failed the limit check |
| fetch_fail_addr | output | 24 | Last logical address whose table read failed |

## Verification
The hard case is a cache lookup or a cache fill landing in the same cycle as an invalidate write. The bench drives the invalidate strobe at a set number of cycles after the request. It aims at the accept cycle, a cycle in the middle of the fetch, and the cycle in which `mem_rsp_valid` is sampled, each with a chosen memory latency. It judges the outcome at the ports. It counts the table reads, checks that the delivered address is still correct, and then repeats the same page. A new read in that repeat proves the stale translation was not kept.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;

   typedef enum logic [1:0] {
      XS_OK    = 2'd0,
      XS_RANGE = 2'd1,
      XS_BUS   = 2'd2
   } xstat_e;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_WAIT = 1'b1
   } fstate_e;

   localparam logic [1:0] RSEL_BASE  = 2'd0;
   localparam logic [1:0] RSEL_LIMIT = 2'd1;
   localparam logic [1:0] RSEL_INVAL = 2'd2;

endpackage

// File: rtl/xlate_index.sv
`timescale 1ns/1ps
module xlate_index #(
   parameter int LA_W     = 24,
   parameter int PA_W     = 29,
   parameter int PG_W     = 12,
   parameter int ENT_LOG2 = 3,
   parameter int LIM_W    = 32
) (
   input  logic [LA_W-1:0]      laddr,
   input  logic [PA_W-1:0]      tbl_base,
   input  logic [LIM_W-1:0]     tbl_limit,
   output logic [LA_W-PG_W-1:0] page_idx,
   output logic [PG_W-1:0]      page_off,
   output logic [PA_W-1:0]      fetch_addr,
   output logic                 beyond_limit
);
   localparam int OFS_W = LA_W - PG_W + ENT_LOG2;

   logic [OFS_W-1:0] byte_ofs;

   if (OFS_W > LIM_W) begin : g_bad_lim
      $error("table byte offset wider than limit register");
   end
   if (OFS_W > PA_W) begin : g_bad_ofs
      $error("table byte offset wider than physical address");
   end

   assign page_idx     = laddr[LA_W-1:PG_W];
   assign page_off     = laddr[PG_W-1:0];
   assign byte_ofs     = {page_idx, {ENT_LOG2{1'b0}}};
   assign beyond_limit = LIM_W'(byte_ofs) >= tbl_limit;
   assign fetch_addr   = tbl_base + PA_W'(byte_ofs);

endmodule

// File: rtl/xlate_cache.sv
`timescale 1ns/1ps
module xlate_cache #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 12,
   parameter int FRM_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [FRM_W-1:0] lk_frame,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [FRM_W-1:0] fill_frame
);
   localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   logic [WAYS-1:0]  vld_q;
   logic [WAYS-1:0]  match;
   logic [TAG_W-1:0] tag_q [WAYS];
   logic [FRM_W-1:0] frm_q [WAYS];
   logic [PTR_W-1:0] rr_q;

   if (WAYS < 1) begin : g_bad_ways
      $error("cache needs at least one way");
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = vld_q[w] && (tag_q[w] == lk_tag);
   end

   always_comb begin
      lk_frame = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) lk_frame = lk_frame | frm_q[w];
      end
   end
   assign lk_hit = |match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int w = 0; w < WAYS; w++) begin
            tag_q[w] <= '0;
            frm_q[w] <= '0;
         end
      end else if (flush) begin
         vld_q <= '0;
      end else if (fill_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (rr_q == PTR_W'(w)) begin
               vld_q[w] <= 1'b1;
               tag_q[w] <= fill_tag;
               frm_q[w] <= fill_frame;
            end
         end
      end
   end

   if (WAYS > 1) begin : g_rr
      always_ff @(posedge clk) begin
         if (!rst_n) rr_q <= '0;
         else if (fill_en && !flush)
            rr_q <= (rr_q == PTR_W'(WAYS-1)) ? '0 : rr_q + 1'b1;
      end
   end else begin : g_single
      assign rr_q = '0;
   end

   // R7
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));

endmodule

// File: rtl/dma_page_xlate.sv
`timescale 1ns/1ps
module dma_page_xlate
   import xlate_pkg::*;
#(
   parameter int LA_W     = 24,
   parameter int PA_W     = 29,
   parameter int PG_W     = 12,
   parameter int DW       = 32,
   parameter int ENT_LOG2 = 3,
   parameter int WAYS     = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic [1:0]      reg_sel,
   input  logic [DW-1:0]   reg_wdata,
   input  logic            req_valid,
   input  logic [LA_W-1:0] req_laddr,
   output logic            req_ready,
   output logic            rsp_valid,
   output logic [1:0]      rsp_status,
   output logic [PA_W-1:0] rsp_paddr,
   output logic            mem_req,
   output logic [PA_W-1:0] mem_addr,
   input  logic            mem_rsp_valid,
   input  logic [DW-1:0]   mem_rsp_data,
   input  logic            mem_rsp_err,
   output logic [LA_W-1:0] bad_xlate_addr,
   output logic [LA_W-1:0] fetch_fail_addr
);
   localparam int TAG_W = LA_W - PG_W;

   if (PA_W > DW) begin : g_bad_pa
      $error("physical address wider than data word");
   end
   if (PG_W >= LA_W) begin : g_bad_pg
      $error("page offset must be narrower than logical address");
   end

   fstate_e         st_q;
   xstat_e          rsp_st_q;
   logic [PA_W-1:0] base_q;
   logic [DW-1:0]   limit_q;
   logic            rsp_v_q, mreq_q, stale_q;
   logic [PA_W-1:0] rsp_pa_q, maddr_q;
   logic [LA_W-1:0] hold_q, bad_q, fail_q;

   logic [TAG_W-1:0] page_idx;
   logic [PG_W-1:0]  page_off;
   logic [PA_W-1:0]  fetch_addr, hit_frame, rsp_frame;
   logic             beyond, hit_raw, hit, inv_now, fill_en;

   assign inv_now   = reg_wr && (reg_sel == RSEL_INVAL);
   assign req_ready = (st_q == FS_IDLE);
   assign hit       = hit_raw && !inv_now;
   assign rsp_frame = mem_rsp_data[PA_W-1:0];
   assign fill_en   = (st_q == FS_WAIT) && mem_rsp_valid && !mem_rsp_err
                      && !stale_q && !inv_now;

   xlate_index #(
      .LA_W(LA_W), .PA_W(PA_W), .PG_W(PG_W), .ENT_LOG2(ENT_LOG2), .LIM_W(DW)
   ) i_index (
      .laddr(req_laddr), .tbl_base(base_q), .tbl_limit(limit_q),
      .page_idx(page_idx), .page_off(page_off),
      .fetch_addr(fetch_addr), .beyond_limit(beyond)
   );

   xlate_cache #(.WAYS(WAYS), .TAG_W(TAG_W), .FRM_W(PA_W)) i_cache (
      .clk(clk), .rst_n(rst_n), .flush(inv_now),
      .lk_tag(page_idx), .lk_hit(hit_raw), .lk_frame(hit_frame),
      .fill_en(fill_en), .fill_tag(hold_q[LA_W-1:PG_W]),
      .fill_frame(rsp_frame)
   );

   // software registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
      end else if (reg_wr) begin
         if (reg_sel == RSEL_BASE)  base_q  <= reg_wdata[PA_W-1:0];
         if (reg_sel == RSEL_LIMIT) limit_q <= reg_wdata;
      end
   end

   // lookup / fetch sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= FS_IDLE;
         rsp_v_q  <= 1'b0;
         rsp_st_q <= XS_OK;
         rsp_pa_q <= '0;
         mreq_q   <= 1'b0;
         maddr_q  <= '0;
         hold_q   <= '0;
         stale_q  <= 1'b0;
         bad_q    <= '0;
         fail_q   <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         mreq_q  <= 1'b0;
         case (st_q)
            FS_IDLE: begin
               if (req_valid) begin
                  if (beyond) begin
                     rsp_v_q  <= 1'b1;
                     rsp_st_q <= XS_RANGE;
                     rsp_pa_q <= '0;
                     bad_q    <= req_laddr;
                  end else if (hit) begin
                     rsp_v_q  <= 1'b1;
                     rsp_st_q <= XS_OK;
                     rsp_pa_q <= hit_frame + PA_W'(page_off);
                  end else begin
                     mreq_q  <= 1'b1;
                     maddr_q <= fetch_addr;
                     hold_q  <= req_laddr;
                     stale_q <= 1'b0;
                     st_q    <= FS_WAIT;
                  end
               end
            end
            FS_WAIT: begin
               if (inv_now) stale_q <= 1'b1;
               if (mem_rsp_valid) begin
                  rsp_v_q <= 1'b1;
                  st_q    <= FS_IDLE;
                  if (mem_rsp_err) begin
                     rsp_st_q <= XS_BUS;
                     rsp_pa_q <= '0;
                     fail_q   <= hold_q;
                  end else begin
                     rsp_st_q <= XS_OK;
                     rsp_pa_q <= rsp_frame + PA_W'(hold_q[PG_W-1:0]);
                  end
               end
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assign rsp_valid       = rsp_v_q;
   assign rsp_status      = rsp_st_q;
   assign rsp_paddr       = rsp_pa_q;
   assign mem_req         = mreq_q;
   assign mem_addr        = maddr_q;
   assign bad_xlate_addr  = bad_q;
   assign fetch_fail_addr = fail_q;

   // R2
   mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R10
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   // R4
   range_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == XS_RANGE) |-> (bad_xlate_addr == $past(req_laddr)));

   // R5
   bus_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == XS_BUS) |-> $past(mem_rsp_valid && mem_rsp_err));

   // R6
   quick_rsp_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_valid && req_ready)) |-> !mem_req);

endmodule

// File: tb/test_dma_page_xlate.sv
`timescale 1ns/1ps
module test_dma_page_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [23:0] req_laddr = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic [1:0]  rsp_status;
   logic [28:0] rsp_paddr;
   logic        mem_req;
   logic [28:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;
   logic [23:0] bad_xlate_addr, fetch_fail_addr;

   always #2 clk = ~clk;

   dma_page_xlate i_dma_page_xlate (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .req_valid(req_valid), .req_laddr(req_laddr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
      .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .mem_rsp_err(mem_rsp_err), .bad_xlate_addr(bad_xlate_addr),
      .fetch_fail_addr(fetch_fail_addr)
   );

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   // bench-side state of the programmed registers and the cache
   logic [28:0] bse = '0;
   logic [31:0] lim = '0;
   bit          err_en = 0;
   int          mem_lat = 0;
   logic [11:0] cur_idx = '0;
   int          fetch_cnt = 0;
   bit          mv [4];
   logic [11:0] mt [4];
   int          mp = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [28:0] frame_of(input logic [11:0] idx);
      int v;
      v = (int'(idx) * 2741 + 341) & 32'h1FFFF;
      return {v[16:0], 12'h000};
   endfunction

   function automatic bit bus_bad(input logic [11:0] idx);
      return err_en && (int'(idx) % 11 == 3);
   endfunction

   function automatic bit model_hit(input logic [11:0] idx);
      for (int w = 0; w < 4; w++) if (mv[w] && mt[w] == idx) return 1;
      return 0;
   endfunction

   task automatic model_fill(input logic [11:0] idx);
      mt[mp] = idx;
      mv[mp] = 1;
      mp = (mp + 1) % 4;
   endtask

   task automatic model_flush();
      for (int w = 0; w < 4; w++) mv[w] = 0;
   endtask

   // table memory model: entry word carries junk in bits 31:29
   logic [28:0] exp_ma;
   int          pend_cnt = 0;
   bit          pend = 0;
   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (mem_req) begin
         fetch_cnt++;
         exp_ma = bse + {14'd0, cur_idx, 3'b000};
         // R2 entry address
         check(mem_addr == exp_ma, "R2", "mem_addr", {3'b0, mem_addr}, {3'b0, exp_ma});
         pend = 1;
         pend_cnt = mem_lat;
      end
      if (pend) begin
         if (pend_cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = {cur_idx[2:0] | 3'b101, frame_of(cur_idx)};
            mem_rsp_err   = bus_bad(cur_idx);
            pend = 0;
         end else begin
            pend_cnt--;
         end
      end
   end

   task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
      if (sel == 2'd0) bse = data[28:0];
      if (sel == 2'd1) lim = data;
      if (sel == 2'd2) model_flush();
   endtask

   task automatic lookup(input logic [23:0] la, input string tag);
      logic [11:0] idx;
      int st, n, f0;
      bit fe;
      logic [28:0] epa;
      idx = la[23:12];
      if ({17'd0, idx, 3'b000} >= lim) st = 1;
      else if (model_hit(idx)) st = 0;
      else if (bus_bad(idx)) st = 2;
      else st = 0;
      fe  = (st != 1) && !model_hit(idx);
      epa = frame_of(idx) + {17'd0, la[11:0]};
      f0  = fetch_cnt;
      @(negedge clk);
      cur_idx = idx;
      check(req_ready == 1'b1, tag, "req_ready before request", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_laddr = la;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 40) begin
         @(negedge clk);
         n++;
      end
      check(rsp_valid == 1'b1, tag, "response seen", {31'd0, rsp_valid}, 32'd1);
      check(rsp_status == st[1:0], tag, "status", {30'd0, rsp_status}, st);
      if (st == 0)
         check(rsp_paddr == epa, tag, "paddr", {3'b0, rsp_paddr}, {3'b0, epa});
      if (st == 1)
         check(bad_xlate_addr == la, "R4", "bad_xlate_addr", {8'd0, bad_xlate_addr}, {8'd0, la});
      if (st == 2)
         check(fetch_fail_addr == la, "R5", "fetch_fail_addr", {8'd0, fetch_fail_addr}, {8'd0, la});
      // R6 / R4: no fetch means answer one cycle after acceptance
      check(fe ? (n >= 1) : (n == 0), fe ? tag : "R6", "latency", n, fe ? 1 : 0);
      check((fetch_cnt - f0) == (fe ? 1 : 0), tag, "table reads", fetch_cnt - f0, fe ? 1 : 0);
      if (st == 0 && fe) model_fill(idx);
   endtask

   // R9 / R10: invalidate strobe dly negedges after the request drive
   task automatic inv_race(input logic [23:0] la, input int lat, input int dly, input bit bogus);
      int f0, n;
      logic [28:0] epa;
      epa = frame_of(la[23:12]) + {17'd0, la[11:0]};
      mem_lat = lat;
      f0 = fetch_cnt;
      @(negedge clk);
      cur_idx = la[23:12];
      req_valid = 1'b1; req_laddr = la;
      if (dly == 0) begin reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0; end
      @(negedge clk);
      req_valid = 1'b0; reg_wr = 1'b0;
      if (bogus) begin
         check(req_ready == 1'b0, "R10", "ready while fetching", {31'd0, req_ready}, 32'd0);
         req_valid = 1'b1; req_laddr = la ^ 24'h35_0000;
      end
      if (dly == 1) begin reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h5A5A; end
      for (int s = 2; s <= dly; s++) begin
         @(negedge clk);
         req_valid = 1'b0; reg_wr = 1'b0;
         if (s == dly) begin reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h0; end
      end
      @(negedge clk);
      reg_wr = 1'b0; req_valid = 1'b0;
      n = 0;
      while (!rsp_valid && n < 40) begin
         @(negedge clk);
         n++;
      end
      check(rsp_valid && rsp_status == 2'd0, "R9", "race response", {30'd0, rsp_status}, 32'd0);
      check(rsp_paddr == epa, "R9", "race paddr", {3'b0, rsp_paddr}, {3'b0, epa});
      check((fetch_cnt - f0) == 1, bogus ? "R10" : "R9", "race table reads", fetch_cnt - f0, 1);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R10", "no extra response", {31'd0, rsp_valid}, 32'd0);
      model_flush();
      if (dly == 0) model_fill(la[23:12]);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   logic [23:0] pg [5];

   initial begin
      for (int w = 0; w < 4; w++) begin mv[w] = 0; mt[w] = '0; end
      repeat (5) @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1", "req_ready", {31'd0, req_ready}, 32'd1);
      check(rsp_valid == 1'b0 && mem_req == 1'b0, "R1", "strobes idle",
            {30'd0, rsp_valid, mem_req}, 32'd0);
      check(bad_xlate_addr == '0 && fetch_fail_addr == '0, "R1", "captures",
            {8'd0, bad_xlate_addr | fetch_fail_addr}, 32'd0);
      rst_n = 1'b1;
      lookup(24'h000123, "R1");

      write_reg(2'd0, 32'h0010_0000);
      write_reg(2'd1, 32'd512);
      write_reg(2'd3, 32'd0);            // R8: code 3 changes nothing
      for (int k = 0; k < 72; k++) begin
         logic [23:0] la;
         la = {12'(k), 12'((k * 53) & 12'hFFF)};
         mem_lat = k % 3;
         lookup(la, "R3");
         lookup(la ^ 24'h000007, "R6");
      end

      // R7 round-robin replacement
      pg[0] = 24'h005_010; pg[1] = 24'h009_7F0; pg[2] = 24'h00D_001;
      pg[3] = 24'h011_FFF; pg[4] = 24'h015_800;
      for (int i = 0; i < 15; i++) lookup(pg[i % 5], "R7");
      for (int i = 0; i < 12; i++) lookup(pg[i % 4], "R7");

      // R8 invalidate with zero and non-zero data
      write_reg(2'd2, 32'd0);
      lookup(pg[0], "R8");
      lookup(pg[0], "R8");
      write_reg(2'd2, 32'hDEAD_BEEF);
      lookup(pg[0], "R8");

      // R2 wrap of base + offset, full table
      write_reg(2'd0, 32'h1FFF_F000);
      write_reg(2'd1, 32'd32768);
      write_reg(2'd2, 32'd0);
      for (int k = 0; k < 100; k++) begin
         mem_lat = k % 4;
         lookup({12'((k * 397 + 11) % 4096), 12'((k * 1237) % 4096)}, "R2");
      end

      // R4 limit boundary
      write_reg(2'd1, 32'd800);
      lookup(24'h063_ABC, "R4");
      lookup(24'h064_000, "R4");
      write_reg(2'd1, 32'd801);
      lookup(24'h064_001, "R4");
      lookup(24'hFFF_FFF, "R4");

      // R5 table read faults
      write_reg(2'd1, 32'd32768);
      write_reg(2'd2, 32'd0);
      err_en = 1;
      for (int k = 0; k < 30; k++) begin
         mem_lat = k % 2;
         lookup({12'(k), 12'h0A0}, "R5");
         lookup({12'(k), 12'h0A4}, "R5");
      end
      err_en = 0;

      // R9 invalidate races, R10 ignored request while busy
      lookup(24'h200_111, "R9");
      inv_race(24'h200_111, 0, 0, 0);
      lookup(24'h200_222, "R9");
      inv_race(24'h300_333, 3, 2, 1);
      lookup(24'h300_333, "R9");
      inv_race(24'h400_444, 1, 2, 0);
      lookup(24'h400_444, "R9");
      inv_race(24'h500_555, 2, 1, 0);
      lookup(24'h500_555, "R9");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule